// File: doc/BRIEF.md
# AXI Egress Port Timeout Monitor

This block sits on one egress port of an interconnect switch, between the switch and a single downstream AXI target. Requests and responses pass through unchanged while the target behaves. Separate timers for reads and for writes measure how long accepted transactions wait for the target to answer. Time is counted in ticks of a prescaler that divides the bus clock.

If either timer reaches the programmed limit, the port enters a failed state. A sticky status flag is set, and an interrupt is raised if it is enabled. From then on the block stops forwarding anything to the target. It answers every transaction it is holding, and every new one, with a local SLVERR response, and it quietly absorbs any late answers the target still sends.

Software recovers the port in three steps. It clears the status flag, turns the timeout enable off and then on again, and lets all held transactions drain. The register decoder, the subsystem reset and the chip-level error collection sit outside this block; they reach it through simple strobes and level inputs.

Top module: `eport_watchdog`

## Requirements
- R1: The prescaler divisor is 10 bits wide and resets to 100. With divisor value D, one tick is produced every max(D,1) clock cycles. Writing the divisor restarts the tick phase.
- R2: A timer runs only while a transaction of its kind is outstanding. A transaction is outstanding from its acceptance on the upstream AR or AW channel until the target ends it (RLAST beat or B). On each tick the timer advances, and expiry happens on the tick at which the advanced count reaches `cfg_limit`. While healthy, all channels pass through unchanged.
- R3: Any response beat from the target (one R beat, or one B) resets that direction's timer to zero.
- R4: Expiry sets `sts_timeout` one cycle later. `irq_out` equals `sts_timeout` gated by the interrupt enable bit.
- R5: While the timeout enable bit is 0, the timers do not run and no expiry occurs, however long a transaction waits.
- R6: In the failed state, `m_arvalid`, `m_awvalid` and `m_wvalid` stay 0, and `m_rready` and `m_bready` stay 1. Late target responses are never passed upstream.
- R7: In the failed state, every read that is held or newly accepted is answered upstream with ARLEN+1 beats. Each beat carries the request's ID, RRESP = 2'b10 and zero data, and RLAST is set on the final beat only.
- R8: In the failed state, upstream W beats are accepted and dropped. Each held or new write gets one B with its AWID and BRESP = 2'b10, issued only after a last W beat has been received for it.
- R9: `sts_timeout` stays 1 until a `cfg_sts_clr` pulse. If a clear and an expiry fall in the same cycle, the expiry wins.
- R10: Forwarding resumes only when four conditions all hold: the status flag is clear, the timeout enable has been seen at 0 during the failed state and is now 1, and no transactions are held. Clearing the status alone does not reopen the port.
- R11: Reads and writes are timed independently. Expiry of either one fails the whole port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div_we | input | 1 | Divisor write strobe |
| cfg_div_val | input | 10 | Divisor value to write |
| cfg_ctl_we | input | 1 | Control write strobe |
| cfg_to_en | input | 1 | Timeout enable value written by the control strobe |
| cfg_irq_en | input | 1 | Interrupt enable value written by the control strobe |
| cfg_sts_clr | input | 1 | Clears the timeout status flag |
| cfg_limit | input | LIM_W | Expiry limit in prescaler ticks |
| sts_timeout | output | 1 | Sticky timeout status |
| irq_out | output | 1 | Masked timeout interrupt |
| s_awvalid | input | 1 | Upstream write address valid |
| s_awready | output | 1 | Upstream write address ready |
| s_awid | input | ID_W | Upstream write ID |
| s_awaddr | input | ADDR_W | Upstream write address |
| s_awlen | input | LEN_W | Upstream write burst length minus one |
| s_wvalid | input | 1 | Upstream write data valid |
| s_wready | output | 1 | Upstream write data ready |
| s_wdata | input | DATA_W | Upstream write data |
| s_wlast | input | 1 | Upstream last write beat |
| s_bvalid | output | 1 | Upstream write response valid |
| s_bready | input | 1 | Upstream write response ready |
| s_bid | output | ID_W | Upstream write response ID |
| s_bresp | output | 2 | Upstream write response code |
| s_arvalid | input | 1 | Upstream read address valid |
| s_arready | output | 1 | Upstream read address ready |
| s_arid | input | ID_W | Upstream read ID |
| s_araddr | input | ADDR_W | Upstream read address |
| s_arlen | input | LEN_W | Upstream read burst length minus one |
| s_rvalid | output | 1 | Upstream read data valid |
| s_rready | input | 1 | Upstream read data ready |
| s_rid | output | ID_W | Upstream read ID |
| s_rdata | output | DATA_W | Upstream read data |
| s_rresp | output | 2 | Upstream read response code |
| s_rlast | output | 1 | Upstream last read beat |
| m_awvalid | output | 1 | Target write address valid |
| m_awready | input | 1 | Target write address ready |
| m_awid | output | ID_W | Target write ID |
| m_awaddr | output | ADDR_W | Target write address |
| m_awlen | output | LEN_W | Target write burst length minus one |
| m_wvalid | output | 1 | Target write data valid |
| m_wready | input | 1 | Target write data ready |
| m_wdata | output | DATA_W | Target write data |
| m_wlast | output | 1 | Target last write beat |
| m_bvalid | input | 1 | Target write response valid |
| m_bready | output | 1 | Target write response ready |
| m_bid | input | ID_W | Target write response ID |
| m_bresp | input | 2 | Target write response code |
| m_arvalid | output | 1 | Target read address valid |
| m_arready | input | 1 | Target read address ready |
| m_arid | output | ID_W | Target read ID |
| m_araddr | output | ADDR_W | Target read address |
| m_arlen | output | LEN_W | Target read burst length minus one |
| m_rvalid | input | 1 | Target read data valid |
| m_rready | output | 1 | Target read data ready |
| m_rid | input | ID_W | Target read ID |
| m_rdata | input | DATA_W | Target read data |
| m_rresp | input | 2 | Target read response code |
| m_rlast | input | 1 | Target last read beat |

## Verification
A wrong timer or prescaler state shows up first as `sts_timeout` rising one or more cycles too early or too late. The bench compares this output against its model on every clock, so a one-cycle shift is caught within the same transaction.

A wrong failed-state flag shows at once on the target side, as a request valid leaking out while the port should be isolated. It also shows at the next upstream response, as an OKAY code or a lost ID in place of the local SLVERR. A corrupted beat counter or held-request queue shows within one burst, as RLAST on the wrong beat or a missing or extra B.

// File: rtl/eport_wd_pkg.sv
package eport_wd_pkg;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam int unsigned DIR_RD = 0;
  localparam int unsigned DIR_WR = 1;
  localparam int unsigned N_DIR  = 2;
endpackage

// File: rtl/eport_wd_presc.sv
module eport_wd_presc #(
  parameter int unsigned DIV_W   = 10,
  parameter int unsigned DIV_RST = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(DIV_RST);

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] pcnt_q, pcnt_d;
  logic [DIV_W-1:0] last_cnt;

  always_comb begin
    last_cnt = (div_q == '0) ? '0 : div_q - 1'b1;
    tick     = (pcnt_q >= last_cnt);
    div_d    = div_we ? div_val : div_q;
    if (div_we || tick) pcnt_d = '0;
    else                pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= RST_VAL;
      pcnt_q <= '0;
    end else begin
      div_q  <= div_d;
      pcnt_q <= pcnt_d;
    end
  end
endmodule

// File: rtl/eport_wd_timer.sv
module eport_wd_timer #(
  parameter int unsigned LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             busy,
  input  logic             restart,
  input  logic [LIM_W-1:0] limit,
  output logic             expire
);
  logic [LIM_W-1:0] cnt_q, cnt_d;
  logic [LIM_W:0]   cnt_inc;
  logic             run;

  always_comb begin
    run     = busy && en && !restart;
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    expire  = run && tick && (cnt_inc >= {1'b0, limit});
    cnt_d   = cnt_q;
    if (!run)                   cnt_d = '0;
    else if (tick && !(&cnt_q)) cnt_d = cnt_inc[LIM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/eport_wd_fifo.sv
module eport_wd_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [PW:0]   cnt_q, cnt_d;
  logic          do_push, do_pop;

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == (PW+1)'(DEPTH));
    do_push = push && !full;
    do_pop  = pop && !empty;
    dout    = mem[rp_q];
    wp_d    = do_push ? wp_q + 1'b1 : wp_q;
    rp_d    = do_pop  ? rp_q + 1'b1 : rp_q;
    cnt_d   = cnt_q;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/eport_watchdog.sv
module eport_watchdog
  import eport_wd_pkg::*;
#(
  parameter int unsigned ID_W    = 4,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned OUTST   = 4,
  parameter int unsigned LIM_W   = 16,
  parameter int unsigned DIV_W   = 10,
  parameter int unsigned DIV_RST = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_div_we,
  input  logic [DIV_W-1:0]  cfg_div_val,
  input  logic              cfg_ctl_we,
  input  logic              cfg_to_en,
  input  logic              cfg_irq_en,
  input  logic              cfg_sts_clr,
  input  logic [LIM_W-1:0]  cfg_limit,
  output logic              sts_timeout,
  output logic              irq_out,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ID_W-1:0]   s_awid,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [LEN_W-1:0]  s_awlen,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              s_wlast,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [ID_W-1:0]   s_bid,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ID_W-1:0]   s_arid,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic [LEN_W-1:0]  s_arlen,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [ID_W-1:0]   s_rid,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rlast,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [ID_W-1:0]   m_awid,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [LEN_W-1:0]  m_awlen,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [DATA_W-1:0] m_wdata,
  output logic              m_wlast,
  input  logic              m_bvalid,
  output logic              m_bready,
  input  logic [ID_W-1:0]   m_bid,
  input  logic [1:0]        m_bresp,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [ID_W-1:0]   m_arid,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [LEN_W-1:0]  m_arlen,
  input  logic              m_rvalid,
  output logic              m_rready,
  input  logic [ID_W-1:0]   m_rid,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rlast
);
  localparam int unsigned RQ_W  = ID_W + LEN_W;
  localparam int unsigned WDN_W = $clog2(OUTST) + 2;

  // control and status registers
  logic to_en_q, to_en_d, irq_en_q, irq_en_d;
  logic sts_q, sts_d, failed_q, failed_d, rearm_q, rearm_d;
  logic [LEN_W-1:0] rbeat_q, rbeat_d;
  logic [WDN_W-1:0] wdone_q, wdone_d;

  logic tick;
  logic [N_DIR-1:0] t_busy, t_restart, t_expire;
  logic any_expire;

  logic [RQ_W-1:0] rq_head;
  logic [ID_W-1:0] rq_id, wq_id;
  logic [LEN_W-1:0] rq_len;
  logic rq_push, rq_pop, rq_empty, rq_full;
  logic wq_push, wq_pop, wq_empty, wq_full;
  logic r_beat, r_last, w_last_in, b_out;

  eport_wd_presc #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_presc (
    .clk(clk), .rst_n(rst_n), .div_we(cfg_div_we), .div_val(cfg_div_val), .tick(tick)
  );

  eport_wd_fifo #(.W(RQ_W), .DEPTH(OUTST)) u_rq (
    .clk(clk), .rst_n(rst_n), .push(rq_push), .din({s_arid, s_arlen}),
    .pop(rq_pop), .dout(rq_head), .empty(rq_empty), .full(rq_full)
  );

  eport_wd_fifo #(.W(ID_W), .DEPTH(OUTST)) u_wq (
    .clk(clk), .rst_n(rst_n), .push(wq_push), .din(s_awid),
    .pop(wq_pop), .dout(wq_id), .empty(wq_empty), .full(wq_full)
  );

  generate
    for (genvar g = 0; g < N_DIR; g++) begin : g_tmr
      eport_wd_timer #(.LIM_W(LIM_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(to_en_q),
        .busy(t_busy[g]), .restart(t_restart[g]), .limit(cfg_limit),
        .expire(t_expire[g])
      );
    end
  endgenerate

  assign rq_id  = rq_head[RQ_W-1:LEN_W];
  assign rq_len = rq_head[LEN_W-1:0];

  // channel steering
  always_comb begin
    m_arid   = s_arid;
    m_araddr = s_araddr;
    m_arlen  = s_arlen;
    m_awid   = s_awid;
    m_awaddr = s_awaddr;
    m_awlen  = s_awlen;
    m_wdata  = s_wdata;
    m_wlast  = s_wlast;
    if (failed_q) begin
      m_arvalid = 1'b0;
      s_arready = !rq_full;
      m_awvalid = 1'b0;
      s_awready = !wq_full;
      m_wvalid  = 1'b0;
      s_wready  = 1'b1;
      m_rready  = 1'b1;
      s_rvalid  = !rq_empty;
      s_rid     = rq_id;
      s_rdata   = '0;
      s_rresp   = RESP_SLVERR;
      s_rlast   = (rbeat_q == rq_len);
      m_bready  = 1'b1;
      s_bvalid  = !wq_empty && (wdone_q != '0);
      s_bid     = wq_id;
      s_bresp   = RESP_SLVERR;
    end else begin
      m_arvalid = s_arvalid && !rq_full;
      s_arready = m_arready && !rq_full;
      m_awvalid = s_awvalid && !wq_full;
      s_awready = m_awready && !wq_full;
      m_wvalid  = s_wvalid;
      s_wready  = m_wready;
      m_rready  = s_rready;
      s_rvalid  = m_rvalid;
      s_rid     = m_rid;
      s_rdata   = m_rdata;
      s_rresp   = m_rresp;
      s_rlast   = m_rlast;
      m_bready  = s_bready;
      s_bvalid  = m_bvalid;
      s_bid     = m_bid;
      s_bresp   = m_bresp;
    end
  end

  // tracking and next state
  always_comb begin
    rq_push   = s_arvalid && s_arready;
    wq_push   = s_awvalid && s_awready;
    r_beat    = failed_q ? (s_rvalid && s_rready) : (m_rvalid && m_rready);
    r_last    = failed_q ? s_rlast : m_rlast;
    rq_pop    = r_beat && r_last && !rq_empty;
    b_out     = s_bvalid && s_bready;
    wq_pop    = failed_q ? b_out : (m_bvalid && m_bready && !wq_empty);
    w_last_in = s_wvalid && s_wready && s_wlast;

    t_busy[DIR_RD]    = !failed_q && !rq_empty;
    t_restart[DIR_RD] = m_rvalid && m_rready;
    t_busy[DIR_WR]    = !failed_q && !wq_empty;
    t_restart[DIR_WR] = m_bvalid && m_bready;
    any_expire        = |t_expire;

    rbeat_d = rbeat_q;
    if (r_beat && !rq_empty) rbeat_d = r_last ? '0 : rbeat_q + 1'b1;

    wdone_d = wdone_q;
    if (w_last_in && !(b_out && wdone_q != '0)) begin
      if (!(&wdone_q)) wdone_d = wdone_q + 1'b1;
    end else if (b_out && !w_last_in && wdone_q != '0) begin
      wdone_d = wdone_q - 1'b1;
    end

    to_en_d  = cfg_ctl_we ? cfg_to_en  : to_en_q;
    irq_en_d = cfg_ctl_we ? cfg_irq_en : irq_en_q;

    sts_d = sts_q;
    if (cfg_sts_clr) sts_d = 1'b0;
    if (any_expire)  sts_d = 1'b1;

    rearm_d = rearm_q;
    if (any_expire)                rearm_d = 1'b0;
    else if (failed_q && !to_en_q) rearm_d = 1'b1;

    failed_d = failed_q;
    if (any_expire) failed_d = 1'b1;
    else if (failed_q && !sts_q && to_en_q && rearm_q && rq_empty && wq_empty)
      failed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_en_q  <= 1'b0;
      irq_en_q <= 1'b0;
      sts_q    <= 1'b0;
      failed_q <= 1'b0;
      rearm_q  <= 1'b0;
      rbeat_q  <= '0;
      wdone_q  <= '0;
    end else begin
      to_en_q  <= to_en_d;
      irq_en_q <= irq_en_d;
      sts_q    <= sts_d;
      failed_q <= failed_d;
      rearm_q  <= rearm_d;
      rbeat_q  <= rbeat_d;
      wdone_q  <= wdone_d;
    end
  end

  assign sts_timeout = sts_q;
  assign irq_out     = sts_q && irq_en_q;
endmodule

// File: rtl/eport_wd_chk.sv
module eport_wd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       failed_q,
  input logic       to_en_q,
  input logic       sts_timeout,
  input logic       irq_out,
  input logic       cfg_sts_clr,
  input logic       m_arvalid,
  input logic       m_awvalid,
  input logic       m_wvalid,
  input logic       m_rready,
  input logic       m_bready,
  input logic       s_rvalid,
  input logic [1:0] s_rresp,
  input logic       s_bvalid,
  input logic [1:0] s_bresp
);
  a_r6_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    failed_q |-> (!m_arvalid && !m_awvalid && !m_wvalid));

  a_r6_drain: assert property (@(posedge clk) disable iff (!rst_n)
    failed_q |-> (m_rready && m_bready));

  a_r7_rd_slverr: assert property (@(posedge clk) disable iff (!rst_n)
    (failed_q && s_rvalid) |-> (s_rresp == 2'b10));

  a_r8_wr_slverr: assert property (@(posedge clk) disable iff (!rst_n)
    (failed_q && s_bvalid) |-> (s_bresp == 2'b10));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_timeout && !cfg_sts_clr) |=> sts_timeout);

  a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!to_en_q && !sts_timeout) |=> !sts_timeout);

  a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_timeout |-> !irq_out);

  a_r4_flag_with_fail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(failed_q) |-> sts_timeout);
endmodule

bind eport_watchdog eport_wd_chk u_chk (.*);

// File: tb/sim_eport_watchdog.sv
module sim_eport_watchdog;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_div_we = 0, cfg_ctl_we = 0, cfg_to_en = 0, cfg_irq_en = 0, cfg_sts_clr = 0;
  logic [9:0] cfg_div_val = '0;
  logic [15:0] cfg_limit = '0;
  logic sts_timeout, irq_out;
  logic s_awvalid = 0, s_awready, s_wvalid = 0, s_wready, s_wlast = 0;
  logic [3:0] s_awid = '0, s_arid = '0;
  logic [31:0] s_awaddr = '0, s_araddr = '0, s_wdata = '0;
  logic [7:0] s_awlen = '0, s_arlen = '0;
  logic s_bvalid, s_bready = 1, s_arvalid = 0, s_arready, s_rvalid, s_rready = 1, s_rlast;
  logic [3:0] s_bid, s_rid;
  logic [1:0] s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic m_awvalid, m_awready = 1, m_wvalid, m_wready = 1, m_wlast;
  logic [3:0] m_awid, m_arid;
  logic [31:0] m_awaddr, m_araddr, m_wdata;
  logic [7:0] m_awlen, m_arlen;
  logic m_bvalid = 0, m_bready, m_arvalid, m_arready = 1, m_rvalid = 0, m_rready, m_rlast = 0;
  logic [3:0] m_bid = '0, m_rid = '0;
  logic [1:0] m_bresp = '0, m_rresp = '0;
  logic [31:0] m_rdata = '0;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eport_watchdog u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model, stepped at the falling edge
  int md_div = 100, md_pc = 0, md_rt = 0, md_wt = 0, md_ro = 0, md_wo = 0;
  bit md_sts = 0, md_fail = 0, md_rearm = 0, md_en = 0, md_ie = 0;
  int n_mar = 0;
  logic [3:0] q_rid[$], q_bid[$];
  logic [1:0] q_rresp[$], q_bresp[$];
  logic q_rlast[$];
  logic [31:0] q_rdata[$];

  always @(negedge clk) begin
    if (rst_n) begin
      int eff;
      bit tick, rrsp, brsp, rbusy, wbusy, rexp, wexp, exitc;
      chk(sts_timeout == md_sts, "R4/R9 status vs model", sts_timeout, md_sts);
      chk(irq_out == (md_sts && md_ie), "R4 irq vs model", irq_out, md_sts && md_ie);
      if (md_fail)
        chk(!m_arvalid && !m_awvalid && !m_wvalid, "R6 isolation", {m_arvalid, m_awvalid, m_wvalid}, 0);
      if (s_rvalid && s_rready) begin
        q_rid.push_back(s_rid); q_rresp.push_back(s_rresp);
        q_rlast.push_back(s_rlast); q_rdata.push_back(s_rdata);
      end
      if (s_bvalid && s_bready) begin q_bid.push_back(s_bid); q_bresp.push_back(s_bresp); end
      if (m_arvalid && m_arready) n_mar++;
      eff   = (md_div == 0) ? 1 : md_div;
      tick  = (md_pc >= eff - 1);
      rrsp  = m_rvalid && m_rready;
      brsp  = m_bvalid && m_bready;
      rbusy = !md_fail && md_ro > 0;
      wbusy = !md_fail && md_wo > 0;
      rexp  = rbusy && md_en && !rrsp && tick && (md_rt + 1 >= cfg_limit);
      wexp  = wbusy && md_en && !brsp && tick && (md_wt + 1 >= cfg_limit);
      exitc = md_fail && !md_sts && md_en && md_rearm && md_ro == 0 && md_wo == 0;
      md_rt = (!rbusy || !md_en || rrsp) ? 0 : (tick ? md_rt + 1 : md_rt);
      md_wt = (!wbusy || !md_en || brsp) ? 0 : (tick ? md_wt + 1 : md_wt);
      if (s_arvalid && s_arready) md_ro++;
      if (s_awvalid && s_awready) md_wo++;
      if (!md_fail) begin
        if (rrsp && m_rlast && md_ro > 0) md_ro--;
        if (brsp && md_wo > 0) md_wo--;
      end else begin
        if (s_rvalid && s_rready && s_rlast) md_ro--;
        if (s_bvalid && s_bready) md_wo--;
      end
      if (rexp || wexp) md_rearm = 0; else if (md_fail && !md_en) md_rearm = 1;
      if (rexp || wexp) md_fail = 1; else if (exitc) md_fail = 0;
      if (cfg_sts_clr) md_sts = 0;
      if (rexp || wexp) md_sts = 1;
      if (cfg_ctl_we) begin md_en = cfg_to_en; md_ie = cfg_irq_en; end
      md_pc = (cfg_div_we || tick) ? 0 : md_pc + 1;
      if (cfg_div_we) md_div = cfg_div_val;
    end
  end

  // ---------------- stimulus helpers
  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic set_ctl(input bit en, input bit ie);
    cfg_ctl_we = 1; cfg_to_en = en; cfg_irq_en = ie; step(); cfg_ctl_we = 0;
  endtask

  task automatic send_ar(input logic [3:0] id, input logic [7:0] len);
    s_arvalid = 1; s_arid = id; s_arlen = len; s_araddr = {24'h0, id, 4'h0};
    while (!s_arready) step();
    step(); s_arvalid = 0;
  endtask

  task automatic send_aw(input logic [3:0] id, input logic [7:0] len);
    s_awvalid = 1; s_awid = id; s_awlen = len;
    while (!s_awready) step();
    step(); s_awvalid = 0;
  endtask

  task automatic send_w(input int beats);
    for (int i = 0; i < beats; i++) begin
      s_wvalid = 1; s_wdata = 32'h100 + i; s_wlast = (i == beats - 1);
      while (!s_wready) step();
      step();
    end
    s_wvalid = 0; s_wlast = 0;
  endtask

  task automatic tgt_r(input logic [3:0] id, input int beats, input int gap, input logic [31:0] d);
    for (int i = 0; i < beats; i++) begin
      m_rvalid = 1; m_rid = id; m_rdata = d + i; m_rresp = 2'b00; m_rlast = (i == beats - 1);
      step(); m_rvalid = 0; m_rlast = 0;
      step(gap);
    end
  endtask

  task automatic clear_q();
    q_rid.delete(); q_rresp.delete(); q_rlast.delete(); q_rdata.delete();
    q_bid.delete(); q_bresp.delete();
  endtask

  task automatic wait_sts(output int cyc);
    cyc = 0;
    while (!sts_timeout && cyc < 600) begin step(); cyc++; end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    int cyc, base;
    step(3);
    rst_n = 1;
    step();
    // reset state
    chk(sts_timeout == 0, "R9 reset status", sts_timeout, 0);
    chk(irq_out == 0, "R4 reset irq", irq_out, 0);
    chk(!s_rvalid && !s_bvalid, "R7 reset no responses", {s_rvalid, s_bvalid}, 0);

    // R1/R2/R11: default divisor 100, limit 2, read never answered
    cfg_limit = 16'd2;
    set_ctl(1, 1);
    clear_q();
    send_ar(4'd3, 8'd2);
    chk(n_mar == 1, "R2 read forwarded while healthy", n_mar, 1);
    wait_sts(cyc);
    chk(cyc >= 100 && cyc <= 202, "R1 expiry spacing with reset divisor", cyc, 200);
    chk(irq_out == 1, "R4 irq raised with enable", irq_out, 1);
    step(6);
    // R7: held read answered locally
    chk(q_rid.size() == 3, "R7 beat count len+1", q_rid.size(), 3);
    for (int i = 0; i < q_rid.size(); i++) begin
      chk(q_rid[i] == 4'd3, "R7 id kept", q_rid[i], 3);
      chk(q_rresp[i] == 2'b10, "R7 SLVERR code", q_rresp[i], 2);
      chk(q_rlast[i] == (i == 2), "R7 rlast position", q_rlast[i], i == 2);
      chk(q_rdata[i] == 0, "R7 zero data", q_rdata[i], 0);
    end
    clear_q();
    send_ar(4'd5, 8'd0);
    step(3);
    chk(q_rid.size() == 1 && q_rid[0] == 4'd5 && q_rresp[0] == 2'b10 && q_rlast[0],
        "R7 new read failed locally", q_rid.size(), 1);
    chk(n_mar == 1, "R6 new read not forwarded", n_mar, 1);
    // R6: late target answer is absorbed
    clear_q();
    chk(m_rready == 1, "R6 target ready while failed", m_rready, 1);
    tgt_r(4'd3, 3, 0, 32'hDEAD0000);
    step(2);
    chk(q_rid.size() == 0, "R6 late data dropped", q_rid.size(), 0);
    // R8: write gets B only after last data
    send_aw(4'd7, 8'd1);
    step(4);
    chk(q_bid.size() == 0, "R8 no B before last beat", q_bid.size(), 0);
    send_w(2);
    step(3);
    chk(q_bid.size() == 1 && q_bid[0] == 4'd7 && q_bresp[0] == 2'b10, "R8 error B with id",
        q_bid.size(), 1);
    // R9/R10: recovery sequence
    chk(sts_timeout == 1, "R9 status held", sts_timeout, 1);
    cfg_sts_clr = 1; step(); cfg_sts_clr = 0;
    step();
    chk(sts_timeout == 0 && irq_out == 0, "R9 clear pulse", sts_timeout, 0);
    clear_q();
    base = n_mar;
    send_ar(4'd9, 8'd0);
    step(3);
    chk(n_mar == base, "R10 still isolated before re-enable", n_mar, base);
    chk(q_rid.size() == 1 && q_rresp[0] == 2'b10, "R10 still failing locally", q_rid.size(), 1);
    set_ctl(0, 1);
    set_ctl(1, 1);
    step(2);
    clear_q();
    send_ar(4'd10, 8'd0);
    chk(n_mar == base + 1, "R10 forwarding resumed", n_mar, base + 1);
    tgt_r(4'd10, 1, 0, 32'hABCD);
    step(2);
    chk(q_rid.size() == 1 && q_rdata[0] == 32'hABCD && q_rresp[0] == 2'b00,
        "R2 pass-through data", q_rdata.size() ? q_rdata[0] : 0, 32'hABCD);

    // R3: beats spaced under the limit keep the timer reset
    cfg_div_we = 1; cfg_div_val = 10'd2; step(); cfg_div_we = 0;
    cfg_limit = 16'd3;
    send_ar(4'd1, 8'd3);
    step(3);
    tgt_r(4'd1, 4, 4, 32'h10);
    step(2);
    chk(sts_timeout == 0, "R3 response resets timer", sts_timeout, 0);

    // R5: disabled timer never expires
    set_ctl(0, 1);
    clear_q();
    send_ar(4'd2, 8'd0);
    step(60);
    chk(sts_timeout == 0, "R5 no expiry when disabled", sts_timeout, 0);
    tgt_r(4'd2, 1, 0, 32'h55);
    step(2);
    chk(q_rid.size() == 1 && q_rresp[0] == 2'b00, "R5 late but normal answer", q_rid.size(), 1);

    // R11/R4: write timer alone fails the port, irq masked
    set_ctl(1, 0);
    clear_q();
    send_aw(4'd4, 8'd0);
    send_w(1);
    wait_sts(cyc);
    chk(sts_timeout == 1, "R11 write timer expiry", sts_timeout, 1);
    chk(irq_out == 0, "R4 irq masked", irq_out, 0);
    step(3);
    chk(q_bid.size() == 1 && q_bid[0] == 4'd4 && q_bresp[0] == 2'b10, "R8 held write failed",
        q_bid.size(), 1);
    set_ctl(1, 1);
    step();
    chk(irq_out == 1, "R4 irq unmasked", irq_out, 1);

    done = 1;
    finish_run();
  end
endmodule